// File: doc/BRIEF.md
# Transmit Start Hold-Off Gate

This block decides when a UART serializer may begin draining its transmit FIFO. Software arms a hold-off so that the transmitter waits while bytes pile up. The hold-off ends when the FIFO fill level reaches a programmed threshold. It also ends when the FIFO has stopped receiving bytes for a fixed inactivity window, so a short final burst is never stranded below the threshold.

The inactivity window is measured by a down-counter. The counter advances on a one-microsecond enable tick. It runs only while the hold-off is active and the FIFO is not empty. Each byte written into the FIFO restarts the window. The FIFO storage and the serializer sit outside the block. The block sees only the write strobe and the current fill level, and it drives one enable line.

Top module: `txhold_gate`

## Requirements
- R1: A synchronous active-high `rst` opens the gate (`tx_en_o` = 1) and leaves the window counter at its full count.
- R2: `arm_i` high in a cycle makes `tx_en_o` low from the next cycle. If `arm_i` coincides with a release condition, arming wins.
- R3: While held, `level_i >= thresh_i` (unsigned) makes `tx_en_o` high in the next cycle.
- R4: The window counter consumes `tick_i` pulses only while the gate is held and `level_i` is nonzero. In any other cycle it returns to its full count.
- R5: Each `load_i` pulse restarts the window at its full count of 64 ticks. A `load_i` in the same cycle as a `tick_i` restarts the window and does not count that tick.
- R6: While held with a nonempty FIFO, the 64th counted tick after the last restart opens the gate in the next cycle. The 63rd counted tick does not open it.
- R7: Once open, the gate stays open until the next `arm_i`.
- R8: A threshold hit and a window expiry in the same cycle open the gate once. A later arm then receives a full 64-tick window.
- R9: Armed with `level_i` = 0 and a nonzero threshold, the gate stays held however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | Request to start a hold-off |
| load_i | input | 1 | Byte written into the transmit FIFO this cycle |
| level_i | input | LVL_W | Current FIFO fill level |
| thresh_i | input | LVL_W | Fill level that releases the hold-off |
| tick_i | input | 1 | One-microsecond time-base enable |
| tx_en_o | output | 1 | Serializer may transmit |

## Verification
The threshold compare and the inactivity expiry are two separate release paths, and they can fire in the same cycle. The bench provokes this by priming the window to its last count with 63 ticks. It then raises the fill level to the threshold in the same cycle as the 64th tick. The case is judged at the enable output: the gate must open exactly once, and a following arm must again need a full 64 ticks to expire. This shows that the counter reloaded cleanly and no second release is pending. The bench also checks that a load arriving together with the final tick restarts the window instead of expiring it.

// File: rtl/txhold_pkg.sv
package txhold_pkg;
    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_HELD = 1'b1
    } gate_e;
endpackage

// File: rtl/txhold_window.sv
// Inactivity window down-counter advanced by a microsecond enable.
module txhold_window #(
    parameter int TICKS = 64,
    localparam int CNT_W = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic load_i,
    input  logic tick_i,
    output logic expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } win_st_t;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    win_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run_i || load_i) begin
            st_d.cnt = FULL;
        end else if (tick_i) begin
            st_d.cnt = (st_q.cnt == LAST) ? FULL : st_q.cnt - LAST;
        end
    end

    assign expire_o = run_i && !load_i && tick_i && (st_q.cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{cnt: FULL};
        else     st_q <= st_d;
    end
endmodule

// File: rtl/txhold_flag.sv
// Hold-off flag: set by arm, cleared by either release path.
module txhold_flag
    import txhold_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic hit_i,
    input  logic expire_i,
    output logic held_o
);
    typedef struct packed {
        gate_e gate;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (arm_i) begin
            st_d.gate = GATE_HELD;
        end else if (st_q.gate == GATE_HELD && (hit_i || expire_i)) begin
            st_d.gate = GATE_OPEN;
        end
    end

    assign held_o = (st_q.gate == GATE_HELD);

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{gate: GATE_OPEN};
        else     st_q <= st_d;
    end
endmodule

// File: rtl/txhold_gate.sv
module txhold_gate #(
    parameter int LVL_W = 5,
    parameter int TICKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             load_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thresh_i,
    input  logic             tick_i,
    output logic             tx_en_o
);
    logic held;
    logic hit;
    logic run;
    logic expire;

    assign hit = (level_i >= thresh_i);
    assign run = held && (level_i != '0);

    txhold_window #(.TICKS(TICKS)) win_i (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .load_i   (load_i),
        .tick_i   (tick_i),
        .expire_o (expire)
    );

    txhold_flag flag_i (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (arm_i),
        .hit_i    (hit),
        .expire_i (expire),
        .held_o   (held)
    );

    assign tx_en_o = !held;
endmodule

// File: rtl/txhold_chk.sv
module txhold_chk #(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             arm_i,
    input logic [LVL_W-1:0] level_i,
    input logic [LVL_W-1:0] thresh_i,
    input logic             tick_i,
    input logic             tx_en_o
);
    AST_RESET_OPENS: assert property (@(posedge clk) rst |=> tx_en_o); // R1
    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !tx_en_o); // R2
    AST_HIT_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_o && !arm_i && level_i >= thresh_i) |=> tx_en_o); // R3
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_o && !arm_i && !tick_i && level_i < thresh_i) |=> !tx_en_o); // R4
    AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (rst)
        (tx_en_o && !arm_i) |=> tx_en_o); // R7
    AST_EMPTY_HELD: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_o && !arm_i && level_i == '0 && thresh_i != '0) |=> !tx_en_o); // R9
endmodule

bind txhold_gate txhold_chk #(.LVL_W(LVL_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (arm_i),
    .level_i  (level_i),
    .thresh_i (thresh_i),
    .tick_i   (tick_i),
    .tx_en_o  (tx_en_o)
);

// File: tb/txhold_gate_tb_top.sv
`timescale 1ns/100ps
module txhold_gate_tb_top;
    localparam int LVL_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic arm_i = 1'b0, load_i = 1'b0, tick_i = 1'b0;
    logic [LVL_W-1:0] level_i = '0, thresh_i = '0;
    logic tx_en_o;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    txhold_gate #(.LVL_W(LVL_W), .TICKS(64)) dut_i (
        .clk(clk), .rst(rst), .arm_i(arm_i), .load_i(load_i),
        .level_i(level_i), .thresh_i(thresh_i), .tick_i(tick_i), .tx_en_o(tx_en_o)
    );

    typedef struct packed {
        logic       arm;
        logic       load;
        logic       tick;
        logic [4:0] lvl;
        logic [4:0] thr;
        logic       exp_en;
    } vec_t;

    // R2 / R3 / R9 sequence; expected enable seen after each step's edge
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 5'd0,  5'd4,  1'b0},
        '{1'b0, 1'b1, 1'b0, 5'd1,  5'd4,  1'b0},
        '{1'b0, 1'b1, 1'b0, 5'd2,  5'd4,  1'b0},
        '{1'b0, 1'b1, 1'b0, 5'd3,  5'd4,  1'b0},
        '{1'b0, 1'b1, 1'b0, 5'd4,  5'd4,  1'b1},
        '{1'b0, 1'b0, 1'b0, 5'd4,  5'd4,  1'b1},
        '{1'b1, 1'b0, 1'b0, 5'd4,  5'd4,  1'b0},
        '{1'b0, 1'b0, 1'b0, 5'd4,  5'd4,  1'b1},
        '{1'b1, 1'b0, 1'b0, 5'd0,  5'd2,  1'b0},
        '{1'b0, 1'b0, 1'b1, 5'd0,  5'd2,  1'b0},
        '{1'b0, 1'b1, 1'b1, 5'd1,  5'd2,  1'b0},
        '{1'b0, 1'b1, 1'b0, 5'd2,  5'd2,  1'b1},
        '{1'b1, 1'b0, 1'b0, 5'd5,  5'd16, 1'b0},
        '{1'b0, 1'b0, 1'b1, 5'd5,  5'd16, 1'b0},
        '{1'b0, 1'b0, 1'b0, 5'd5,  5'd5,  1'b1}
    };

    task automatic step(input logic a, input logic l, input logic t,
                        input logic [4:0] lv, input logic [4:0] th);
        @(negedge clk);
        arm_i = a; load_i = l; tick_i = t; level_i = lv; thresh_i = th;
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n, input logic [4:0] lv, input logic [4:0] th);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, lv, th);
    endtask

    task automatic check(input logic expv, input string tag);
        total++;
        if (tx_en_o !== expv) begin
            bad++;
            $display("FAIL %s: tx_en_o actual=%b expected=%b", tag, tx_en_o, expv);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: gate open under and after reset
        repeat (3) @(posedge clk);
        #1;
        check(1'b1, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            step(VEC[k].arm, VEC[k].load, VEC[k].tick, VEC[k].lvl, VEC[k].thr);
            check(VEC[k].exp_en, $sformatf("R2/R3 vector %0d", k));
        end

        // R6: expiry on the 64th tick after the last load
        step(1'b1, 1'b0, 1'b0, 5'd0, 5'd8);
        step(1'b0, 1'b1, 1'b0, 5'd1, 5'd8);
        ticks(63, 5'd1, 5'd8);
        check(1'b0, "R6 63 ticks still held");
        ticks(1, 5'd1, 5'd8);
        check(1'b1, "R6 64th tick releases");
        ticks(5, 5'd1, 5'd8);
        check(1'b1, "R7 stays open after expiry");

        // R5: a load mid-window restarts the count
        step(1'b1, 1'b0, 1'b0, 5'd1, 5'd8);
        step(1'b0, 1'b1, 1'b0, 5'd1, 5'd8);
        ticks(40, 5'd1, 5'd8);
        step(1'b0, 1'b1, 1'b0, 5'd2, 5'd8);
        ticks(63, 5'd2, 5'd8);
        check(1'b0, "R5 reload extends window");
        ticks(1, 5'd2, 5'd8);
        check(1'b1, "R5 release 64 ticks after reload");

        // R5: a load together with the final tick wins
        step(1'b1, 1'b0, 1'b0, 5'd2, 5'd8);
        ticks(63, 5'd2, 5'd8);
        step(1'b0, 1'b1, 1'b1, 5'd3, 5'd8);
        check(1'b0, "R5 load beats final tick");
        ticks(63, 5'd3, 5'd8);
        check(1'b0, "R5 full window after collision");
        ticks(1, 5'd3, 5'd8);
        check(1'b1, "R5 release after collision window");

        // R9 / R4: armed and empty, ticks do nothing
        step(1'b1, 1'b0, 1'b0, 5'd0, 5'd4);
        ticks(200, 5'd0, 5'd4);
        check(1'b0, "R9 empty FIFO stays held");
        step(1'b0, 1'b1, 1'b0, 5'd1, 5'd4);
        ticks(63, 5'd1, 5'd4);
        check(1'b0, "R4 window starts at first byte");
        ticks(1, 5'd1, 5'd4);
        check(1'b1, "R4 release after first byte window");

        // R8: threshold hit and expiry together
        step(1'b1, 1'b0, 1'b0, 5'd0, 5'd2);
        step(1'b0, 1'b1, 1'b0, 5'd1, 5'd2);
        ticks(63, 5'd1, 5'd2);
        check(1'b0, "R8 primed window");
        step(1'b0, 1'b0, 1'b1, 5'd2, 5'd2);
        check(1'b1, "R8 single release");
        ticks(3, 5'd2, 5'd2);
        check(1'b1, "R8 no second event");
        step(1'b1, 1'b0, 1'b0, 5'd2, 5'd3);
        ticks(63, 5'd2, 5'd3);
        check(1'b0, "R8 next arm gets full window");
        ticks(1, 5'd2, 5'd3);
        check(1'b1, "R8 next window expires at 64");

        // R1: reset while held clears flag and window
        step(1'b1, 1'b0, 1'b0, 5'd1, 5'd8);
        ticks(30, 5'd1, 5'd8);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1'b1, "R1 reset releases hold");
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b0, 1'b0, 5'd1, 5'd8);
        ticks(63, 5'd1, 5'd8);
        check(1'b0, "R1 window full after reset");
        ticks(1, 5'd1, 5'd8);
        check(1'b1, "R1 expiry after reset window");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule